// File: doc/BRIEF.md
# Table-Driven Register Window Decoder

This block is the central address decoder and read-data combiner for a bank of peripheral registers. A compile-time table lists, for each peripheral, a base word address and how many low address bits that peripheral decodes internally. Each entry therefore covers an aligned window of 2^k words. On every clock edge that carries a bus strobe, the block compares the bus address against every window. It raises the select line of the entry that matches and passes the low address bits to all peripherals, so that a peripheral with several words can pick one.

Read data is formed without an indexed multiplexer. The accumulator starts from zero, and the readback word of each matching entry is ORed into it. A parameter adds zero to two register stages after the read data. These stages shorten the combining path, and the select and low-address outputs keep their one-cycle timing whatever this setting is. The table is checked during elaboration for overlapping windows, misaligned bases, windows that extend past the address space, and internal address bits wider than the shared low-address bus. With the default table, entry 0 covers word 7, entry 1 covers word 5, and entry 2 covers words 10 and 11.

Top module: `regmap_decoder`

## Requirements
- R1: While reset is low, and on the first sample after it, `per_sel`, `per_loc_addr` and `bus_rdata` are all zero.
- R2: A single-word entry (0 internal bits) is selected only at its exact base address. With the default table, address 7 raises `per_sel` bit 0 and address 5 raises bit 1.
- R3: An entry with k internal bits is selected for every address from base to base+2^k-1 and for no other. Entry 2 (base 10, k=1) raises `per_sel` bit 2 at addresses 10 and 11, and stays low at 9 and 12.
- R4: A select is raised in the cycle after the clock edge that samples `bus_strobe` high, and it lasts one cycle only. Strobes on back-to-back cycles give back-to-back selects.
- R5: `per_loc_addr` takes the low LOC_W bits of `bus_addr` at each strobed edge and holds that value while no strobe is present.
- R6: `bus_rdata` equals the OR of the readback words of the matched entries only. The words of entries that do not match have no effect. Entry i's word is slice [i*DATA_W +: DATA_W] of `per_rdata`.
- R7: An address that falls in no window raises no select and returns all-zero read data.
- R8: Read data for a strobe sampled at edge t appears after edge t+RD_PIPE and stays valid until edge t+1+RD_PIPE. The timing of the selects does not depend on RD_PIPE.
- R9: On cycles without a strobe, all selects are zero and, after the pipeline delay, read data is zero.
- R10: At most one select line is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_strobe | input | 1 | Single-cycle access strobe from the bus master |
| bus_addr | input | ADDR_W | Word address of the access |
| per_rdata | input | N_REG*DATA_W | Readback words of all entries, entry i at slice i |
| per_sel | output | N_REG | One registered select per table entry |
| per_loc_addr | output | LOC_W | Low address bits shared by all peripherals |
| bus_rdata | output | DATA_W | Combined read data after 1+RD_PIPE edges |

## Verification
The vector table drives each mapped address, the two addresses just outside the two-word window, the gap address between the single-word entries, and the lowest and highest addresses of the space. These patterns separate a decoder that masks too few or too many low bits from a correct one, and they expose any wrong base comparison. Each peripheral word has its own bit pattern, so a leak of an unselected word into the read data shows up as extra bits. Back-to-back strobes, idle cycles after an access, and a reset in the middle of the pipeline show whether selects and read data keep their separate latencies and whether both return to zero.

// File: rtl/regdec_pkg.sv
// Package: shared helpers for the register window decoder.
// Assumes: window sizes are powers of two given as a count of internal bits.
package regdec_pkg;

    // Largest internal-bit count accepted for any table entry.
    localparam int MAX_LOWB = 16;

    // Number of words covered by a window with the given internal bits.
    function automatic longint win_words(input int lowb);
        return longint'(1) << lowb;
    endfunction

    // True when two half-open word ranges share at least one address.
    function automatic bit ranges_overlap(input longint b0, input longint s0,
                                          input longint b1, input longint s1);
        return (b0 < b1 + s1) && (b1 < b0 + s0);
    endfunction

endpackage

// File: rtl/regdec_window.sv
// Module: regdec_window
// Compares one address with one aligned window and reports a hit.
// Assumes: BASE is aligned to 2**LOWB (checked by the top at elaboration).
module regdec_window #(
    parameter int ADDR_W = 8,
    parameter int BASE   = 0,
    parameter int LOWB   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

    // Purpose: compare only the bits above the peripheral's internal bits.
    always_comb begin
        hit = ((addr >> LOWB) == (BASE_V >> LOWB));
    end
endmodule

// File: rtl/regdec_orsum.sv
// Module: regdec_orsum
// AND-OR combine: starts from zero and ORs in each enabled word.
// Assumes: enables are at most one-hot, though any pattern is legal.
module regdec_orsum #(
    parameter int N = 3,
    parameter int W = 16
) (
    input  logic [N-1:0]   en,
    input  logic [N*W-1:0] words,
    output logic [W-1:0]   sum
);
    // Purpose: gate each word with its enable and OR the results together.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum | (words[i*W +: W] & {W{en[i]}});
        end
    end
endmodule

// File: rtl/regdec_pipe.sv
// Module: regdec_pipe
// Delay line of DEPTH register stages with synchronous active-low reset.
// Assumes: DEPTH is small; DEPTH==0 gives a plain wire.
module regdec_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (DEPTH == 0) begin : g_wire
        assign dout = din;
    end else begin : g_regs
        logic [W-1:0] stage [DEPTH];

        // Purpose: shift data one stage per clock and clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
            end else begin
                stage[0] <= din;
                for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
        end
        assign dout = stage[DEPTH-1];
    end
endmodule

// File: rtl/regmap_decoder.sv
// Module: regmap_decoder (top)
// Central address decoder and readback combiner driven by a window table.
// Each entry i covers 2**LOWB_TAB[i] words from BASE_TAB[i]. Selects and the
// shared low address are registered once; read data gets RD_PIPE more stages.
// Assumes: peripherals present their readback words continuously; the table
// is legal (checked at elaboration).
module regmap_decoder #(
    parameter int ADDR_W            = 8,
    parameter int DATA_W            = 16,
    parameter int N_REG             = 3,
    parameter int LOC_W             = 1,
    parameter int RD_PIPE           = 1,
    parameter int BASE_TAB [N_REG]  = '{7, 5, 10},
    parameter int LOWB_TAB [N_REG]  = '{0, 0, 1}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_strobe,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [N_REG*DATA_W-1:0] per_rdata,
    output logic [N_REG-1:0]        per_sel,
    output logic [LOC_W-1:0]        per_loc_addr,
    output logic [DATA_W-1:0]       bus_rdata
);
    import regdec_pkg::*;

    localparam longint SPACE = longint'(1) << ADDR_W;

    // Purpose: elaboration-time legality check of the window table.
    function automatic bit table_ok();
        if (RD_PIPE < 0 || RD_PIPE > 2) return 1'b0;
        for (int i = 0; i < N_REG; i++) begin
            if (LOWB_TAB[i] < 0 || LOWB_TAB[i] > MAX_LOWB) return 1'b0;
            if (LOWB_TAB[i] > LOC_W) return 1'b0;
            if ((longint'(BASE_TAB[i]) % win_words(LOWB_TAB[i])) != 0) return 1'b0;
            if (BASE_TAB[i] < 0 ||
                longint'(BASE_TAB[i]) + win_words(LOWB_TAB[i]) > SPACE) return 1'b0;
            for (int j = i + 1; j < N_REG; j++) begin
                if (ranges_overlap(longint'(BASE_TAB[i]), win_words(LOWB_TAB[i]),
                                   longint'(BASE_TAB[j]), win_words(LOWB_TAB[j])))
                    return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    localparam bit TABLE_OK = table_ok();

    if (!TABLE_OK) begin : g_bad_table
        $error("regmap_decoder: window table overlaps, is misaligned or out of range");
    end

    logic [N_REG-1:0]  hit;
    logic [N_REG-1:0]  hit_g;
    logic [DATA_W-1:0] rd_sum;
    logic [DATA_W-1:0] rd_q;

    for (genvar g = 0; g < N_REG; g++) begin : g_win
        regdec_window #(
            .ADDR_W (ADDR_W),
            .BASE   (BASE_TAB[g]),
            .LOWB   (LOWB_TAB[g])
        ) u_win (
            .addr (bus_addr),
            .hit  (hit[g])
        );
    end

    // Purpose: only a strobed access may select a peripheral.
    always_comb begin
        hit_g = hit & {N_REG{bus_strobe}};
    end

    regdec_orsum #(
        .N (N_REG),
        .W (DATA_W)
    ) u_orsum (
        .en    (hit_g),
        .words (per_rdata),
        .sum   (rd_sum)
    );

    // Purpose: register selects, shared low address and first read stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sel      <= '0;
            per_loc_addr <= '0;
            rd_q         <= '0;
        end else begin
            per_sel <= hit_g;
            rd_q    <= rd_sum;
            if (bus_strobe) per_loc_addr <= bus_addr[LOC_W-1:0];
        end
    end

    regdec_pipe #(
        .W     (DATA_W),
        .DEPTH (RD_PIPE)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_q),
        .dout  (bus_rdata)
    );
endmodule

// File: rtl/regmap_decoder_checker.sv
// Module: regmap_decoder_checker
// Temporal checks on the decoder ports, attached with bind.
// Assumes: reset is asserted from time zero.
module regmap_decoder_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int N_REG   = 3,
    parameter int LOC_W   = 1,
    parameter int RD_PIPE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_strobe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_REG-1:0]  per_sel,
    input logic [LOC_W-1:0]  per_loc_addr,
    input logic [DATA_W-1:0] bus_rdata
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_sel)); // R10

    AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> (per_sel == '0)); // R4

    AST_LOC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (per_loc_addr == $past(bus_addr[LOC_W-1:0]))); // R5

    AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> $stable(per_loc_addr)); // R5

    if (RD_PIPE == 0) begin : g_nopipe
        AST_NO_SEL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (per_sel == '0) |-> (bus_rdata == '0)); // R7
    end else begin : g_pipe
        AST_NO_SEL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(per_sel, RD_PIPE) == '0) |-> (bus_rdata == '0)); // R7
    end
endmodule

bind regmap_decoder regmap_decoder_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .N_REG   (N_REG),
    .LOC_W   (LOC_W),
    .RD_PIPE (RD_PIPE)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_strobe   (bus_strobe),
    .bus_addr     (bus_addr),
    .per_sel      (per_sel),
    .per_loc_addr (per_loc_addr),
    .bus_rdata    (bus_rdata)
);

// File: tb/regmap_decoder_bench.sv
// Bench for regmap_decoder with the default table (7, 5, 10..11).
module regmap_decoder_bench;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int N_REG   = 3;
    localparam int LOC_W   = 1;
    localparam int RD_PIPE = 1;

    localparam logic [DATA_W-1:0] W0 = 16'h00A1;
    localparam logic [DATA_W-1:0] W1 = 16'h0B02;
    localparam logic [DATA_W-1:0] W2 = 16'hC004;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [N_REG-1:0]  sel;
        logic [DATA_W-1:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'd7,   3'b001, W0},
        '{8'd5,   3'b010, W1},
        '{8'd10,  3'b100, W2},
        '{8'd11,  3'b100, W2},
        '{8'd9,   3'b000, 16'h0000},
        '{8'd12,  3'b000, 16'h0000},
        '{8'd6,   3'b000, 16'h0000},
        '{8'd8,   3'b000, 16'h0000},
        '{8'd0,   3'b000, 16'h0000},
        '{8'd255, 3'b000, 16'h0000}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bus_strobe = 1'b0;
    logic [ADDR_W-1:0]       bus_addr = '0;
    logic [N_REG*DATA_W-1:0] per_rdata;
    logic [N_REG-1:0]        per_sel;
    logic [LOC_W-1:0]        per_loc_addr;
    logic [DATA_W-1:0]       bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    assign per_rdata = {W2, W1, W0};

    always #4 clk = ~clk;

    regmap_decoder #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .N_REG   (N_REG),
        .LOC_W   (LOC_W),
        .RD_PIPE (RD_PIPE)
    ) u_regmap_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_strobe   (bus_strobe),
        .bus_addr     (bus_addr),
        .per_rdata    (per_rdata),
        .per_sel      (per_sel),
        .per_loc_addr (per_loc_addr),
        .bus_rdata    (bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Strobe one access, then check select/low address and read data.
    task automatic access(input string req, input logic [ADDR_W-1:0] a,
                          input logic [N_REG-1:0] esel, input logic [DATA_W-1:0] edat);
        @(negedge clk);
        bus_strobe = 1'b1;
        bus_addr   = a;
        @(negedge clk);
        bus_strobe = 1'b0;
        chk({req, " sel"}, 32'(per_sel), 32'(esel));
        chk({req, " loc R5"}, 32'(per_loc_addr), 32'(a[LOC_W-1:0]));
        for (int k = 0; k < RD_PIPE; k++) @(negedge clk);
        chk({req, " data R6"}, 32'(bus_rdata), 32'(edat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sel", 32'(per_sel), 0);
        chk("R1 loc", 32'(per_loc_addr), 0);
        chk("R1 data", 32'(bus_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(per_sel), 0);

        // R2 R3 R7: table walk
        for (int v = 0; v < NV; v++) begin
            access(VEC[v].sel == 0 ? "R7 unmapped" :
                   (VEC[v].sel[2] ? "R3 two-word" : "R2 single"),
                   VEC[v].addr, VEC[v].sel, VEC[v].data);
        end

        // R9 R5: idle after access at 11: no select, zero data, loc held at 1
        access("R3 pre-idle", 8'd11, 3'b100, W2);
        repeat (2) @(negedge clk);
        chk("R9 idle sel", 32'(per_sel), 0);
        chk("R9 idle data", 32'(bus_rdata), 0);
        chk("R5 loc hold", 32'(per_loc_addr), 1);

        // R4 R8: back-to-back strobes 7 then 10
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = 8'd7;
        @(negedge clk);
        bus_addr = 8'd10;
        chk("R4 b2b first sel", 32'(per_sel), 32'b001);
        chk("R8 data not yet", 32'(bus_rdata), 0);
        @(negedge clk);
        bus_strobe = 1'b0;
        chk("R4 b2b second sel", 32'(per_sel), 32'b100);
        chk("R8 first data", 32'(bus_rdata), 32'(W0));
        @(negedge clk);
        chk("R4 sel one cycle", 32'(per_sel), 0);
        chk("R8 second data", 32'(bus_rdata), 32'(W2));
        @(negedge clk);
        chk("R8 data one cycle", 32'(bus_rdata), 0);

        // R1: reset in mid-flight clears pipeline
        bus_strobe = 1'b1; bus_addr = 8'd5;
        @(negedge clk);
        bus_strobe = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset sel", 32'(per_sel), 0);
        chk("R1 mid reset data", 32'(bus_rdata), 0);
        rst_n = 1'b1;
        access("R2 after reset", 8'd5, 3'b010, W1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule